// File: doc/BRIEF.md
# MDIO Management Slave Register Interface

This block is the serial management slave of an Ethernet PHY. It runs directly on the management clock. Each rising edge samples the bidirectional data line. The block hunts for a run of at least 32 ones followed by the `01` start marker, then decodes a 2-bit opcode, a 5-bit device address and a 5-bit register index. A frame is accepted only when the device address equals the value on the five strap inputs. Any other frame is dropped, and the block waits for a new run of ones.

An accepted read leaves the line released for one bit time and drives a zero for the next. It then shifts out a 16-bit word, most significant bit first, and releases the line. Every driven bit changes just after a rising edge, so the master can sample it on the following rising edge. An accepted write collects 16 data bits after the two turnaround bits and updates the addressed register on the edge that samples the last bit.

The register set is small:
- a writable control word and a writable advertisement word;
- read-only status and identifier constants;
- an interrupt-enable word;
- a sticky interrupt-status word that clears when it is read.

The interrupt output is high while any enabled status bit is set.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: While reset is active and after it is released, mdio_oe_o and irq_o are low. The reset values are register 0 = 16'h3100, register 4 = 16'h01E1 and register 22 = 16'h0000.
- R2: A frame is decoded only after at least 32 consecutive ones, followed by a 0 and then a 1. With 31 ones, or with a start marker of 00, the block ignores the frame and never drives the line.
- R3: Opcode 2'b10 is a read and 2'b01 is a write. Opcodes 2'b00 and 2'b11 are ignored: there is no drive and no register change.
- R4: The frame's 5-bit device address must equal phy_addr_i. On a mismatch there is no drive and no register update. A new strap value takes effect for the next frame.
- R5: On a read, mdio_oe_o stays low for the first bit time after the last register-index bit. It then stays high for exactly 17 bit times: first a 0, then the 16 data bits MSB first, each changing after a rising edge. After that the line is released.
- R6: On a write, the two turnaround bits are not checked. The 16 data bits arrive MSB first and update registers 0, 4 or 22 on the edge that samples the last data bit. A later read returns the written word.
- R7: Registers 1, 2 and 3 read as the constants 16'h7809, 16'h0015 and 16'hF450. Registers 5 and 6 read as zero. Writes to any of these are ignored.
- R8: All other register indices except 22 and 23 read as zero and ignore writes.
- R9: Status bit i in register 23 is set by irq_src_i[i] being high at a rising edge. It stays set until register 23 is read.
- R10: A read of register 23 returns the status and clears it on the edge of the first turnaround bit. A source bit that is high on that same edge stays set.
- R11: irq_o is high exactly while some bit is set in both register 23 and register 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; all state changes on its rising edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mdio_i | input | 1 | Sampled value of the management data line |
| mdio_o | output | 1 | Value the slave drives on the data line |
| mdio_oe_o | output | 1 | Drive enable for the data line; low means high-impedance |
| phy_addr_i | input | 5 | Strapped device address |
| irq_src_i | input | 16 | Per-bit interrupt event inputs, sampled on each rising edge |
| irq_o | output | 1 | Interrupt request to the controller |

## Verification
The bench aims at the frame-boundary cases:
- A preamble one bit short must not open a frame. A design with an off-by-one count would answer it and drive the line.
- A broken start marker, the two unused opcodes and a foreign device address are each sent. A decoder that let any of them through would either drive the turnaround zero or change a register.
- The read window is checked bit by bit against the model. Starting one edge early would collide with the master's last address bit, and releasing one edge late would hold the line past the data.
- For the clear-on-read status, a source pulse is sent on the very edge that clears it. A design that cleared after merging new events would lose that pulse and drop the interrupt.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  typedef enum logic [2:0] {
    S_PRE, S_START, S_OP, S_ADDR, S_RTA, S_RDATA, S_WTA, S_WDATA
  } mdio_st_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [4:0] A_CTRL = 5'd0;
  localparam logic [4:0] A_STAT = 5'd1;
  localparam logic [4:0] A_IDHI = 5'd2;
  localparam logic [4:0] A_IDLO = 5'd3;
  localparam logic [4:0] A_ADV  = 5'd4;
  localparam logic [4:0] A_IEN  = 5'd22;
  localparam logic [4:0] A_IST  = 5'd23;
endpackage

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mdio_i,
  input  logic [4:0]    phy_addr_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  output logic          rd_en_o,
  output logic          wr_en_o,
  output logic [4:0]    reg_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int PCW = $clog2(PRE_LEN + 1);
  localparam int BCW = $clog2(DW + 1);

  mdio_st_e       state_q;
  logic [PCW-1:0] pre_cnt_q;
  logic [BCW-1:0] bit_cnt_q;
  logic [1:0]     op_q;
  logic [8:0]     hdr_q;
  logic [4:0]     reg_q;
  logic [DW-1:0]  sh_q;
  logic           o_q, oe_q;

  assign rd_en_o    = (state_q == S_RTA);
  assign wr_en_o    = (state_q == S_WDATA) && (bit_cnt_q == BCW'(DW - 1));
  assign wr_data_o  = {sh_q[DW-2:0], mdio_i};
  assign reg_addr_o = reg_q;
  assign mdio_o     = o_q;
  assign mdio_oe_o  = oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_PRE;
      pre_cnt_q <= '0;
      bit_cnt_q <= '0;
      op_q      <= '0;
      hdr_q     <= '0;
      reg_q     <= '0;
      sh_q      <= '0;
      o_q       <= 1'b0;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        S_PRE: begin
          if (mdio_i) begin
            if (pre_cnt_q != PCW'(PRE_LEN)) pre_cnt_q <= pre_cnt_q + 1'b1;
          end else if (pre_cnt_q == PCW'(PRE_LEN)) begin
            state_q <= S_START;
          end else begin
            pre_cnt_q <= '0;
          end
        end
        S_START: begin
          pre_cnt_q <= '0;
          bit_cnt_q <= '0;
          state_q   <= mdio_i ? S_OP : S_PRE;
        end
        S_OP: begin
          op_q      <= {op_q[0], mdio_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCW'(1)) begin
            bit_cnt_q <= '0;
            state_q   <= S_ADDR;
          end
        end
        S_ADDR: begin
          hdr_q     <= {hdr_q[7:0], mdio_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCW'(9)) begin
            bit_cnt_q <= '0;
            reg_q     <= {hdr_q[3:0], mdio_i};
            if (hdr_q[8:4] == phy_addr_i && op_q == OP_RD)      state_q <= S_RTA;
            else if (hdr_q[8:4] == phy_addr_i && op_q == OP_WR) state_q <= S_WTA;
            else                                                state_q <= S_PRE;
          end
        end
        S_RTA: begin
          oe_q      <= 1'b1;
          o_q       <= 1'b0;
          sh_q      <= rd_data_i;
          bit_cnt_q <= '0;
          state_q   <= S_RDATA;
        end
        S_RDATA: begin
          if (bit_cnt_q == BCW'(DW)) begin
            oe_q      <= 1'b0;
            o_q       <= 1'b0;
            pre_cnt_q <= '0;
            state_q   <= S_PRE;
          end else begin
            o_q       <= sh_q[DW-1];
            sh_q      <= {sh_q[DW-2:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end
        end
        S_WTA: begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCW'(1)) begin
            bit_cnt_q <= '0;
            state_q   <= S_WDATA;
          end
        end
        S_WDATA: begin
          sh_q      <= {sh_q[DW-2:0], mdio_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
          if (bit_cnt_q == BCW'(DW - 1)) begin
            pre_cnt_q <= '0;
            state_q   <= S_PRE;
          end
        end
        default: state_q <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int             DW       = 16,
  parameter logic [DW-1:0]  CTRL_RST = 16'h3100,
  parameter logic [DW-1:0]  ADV_RST  = 16'h01E1,
  parameter logic [DW-1:0]  STAT_VAL = 16'h7809,
  parameter logic [DW-1:0]  ID_HI    = 16'h0015,
  parameter logic [DW-1:0]  ID_LO    = 16'hF450
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [4:0]    addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [DW-1:0] irq_stat_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] irq_en_o
);
  logic [DW-1:0] ctrl_q, adv_q, ien_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
      adv_q  <= ADV_RST;
      ien_q  <= '0;
    end else if (wr_en_i) begin
      case (addr_i)
        A_CTRL:  ctrl_q <= wr_data_i;
        A_ADV:   adv_q  <= wr_data_i;
        A_IEN:   ien_q  <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rd_data_o = ctrl_q;
      A_STAT:  rd_data_o = STAT_VAL;
      A_IDHI:  rd_data_o = ID_HI;
      A_IDLO:  rd_data_o = ID_LO;
      A_ADV:   rd_data_o = adv_q;
      A_IEN:   rd_data_o = ien_q;
      A_IST:   rd_data_o = irq_stat_i;
      default: rd_data_o = '0;
    endcase
  end

  assign irq_en_o = ien_q;
endmodule

// File: rtl/mdio_irq.sv
`timescale 1ns/1ps
module mdio_irq #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] src_i,
  input  logic          clr_i,
  input  logic [DW-1:0] en_i,
  output logic [DW-1:0] stat_o,
  output logic          irq_o
);
  logic [DW-1:0] stat_q;

  for (genvar i = 0; i < DW; i++) begin : g_bit
    // clear first, then merge new events so a same-edge event survives
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[i] <= 1'b0;
      else         stat_q[i] <= (stat_q[i] & ~clr_i) | src_i[i];
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & en_i);
endmodule

// File: rtl/mdio_mgmt_slave.sv
`timescale 1ns/1ps
module mdio_mgmt_slave
  import mdio_pkg::*;
#(
  parameter int DW      = 16,
  parameter int PRE_LEN = 32
) (
  input  logic          mdc_i,
  input  logic          rst_ni,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic [4:0]    phy_addr_i,
  input  logic [DW-1:0] irq_src_i,
  output logic          irq_o
);
  logic          rd_en, wr_en;
  logic [4:0]    reg_addr;
  logic [DW-1:0] rd_data, wr_data, irq_stat, irq_en;

  mdio_frame #(.DW(DW), .PRE_LEN(PRE_LEN)) i_frame (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .mdio_i     (mdio_i),
    .phy_addr_i (phy_addr_i),
    .rd_data_i  (rd_data),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .rd_en_o    (rd_en),
    .wr_en_o    (wr_en),
    .reg_addr_o (reg_addr),
    .wr_data_o  (wr_data)
  );

  mdio_regs #(.DW(DW)) i_regs (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .addr_i     (reg_addr),
    .wr_data_i  (wr_data),
    .irq_stat_i (irq_stat),
    .rd_data_o  (rd_data),
    .irq_en_o   (irq_en)
  );

  mdio_irq #(.DW(DW)) i_irq (
    .clk_i  (mdc_i),
    .rst_ni (rst_ni),
    .src_i  (irq_src_i),
    .clr_i  (rd_en && reg_addr == A_IST),
    .en_i   (irq_en),
    .stat_o (irq_stat),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/mdio_mgmt_checker.sv
`timescale 1ns/1ps
module mdio_mgmt_checker #(
  parameter int DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mdio_o,
  input logic          mdio_oe_o,
  input logic          irq_o,
  input logic [DW-1:0] irq_src_i,
  input logic          rd_en,
  input logic          wr_en,
  input logic [4:0]    reg_addr,
  input logic [DW-1:0] irq_stat
);
  logic [5:0] oe_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        oe_run_q <= '0;
    else if (mdio_oe_o) oe_run_q <= oe_run_q + 1'b1;
    else                oe_run_q <= '0;
  end

  assert_ta_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);

  assert_drive_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> oe_run_q < 6'(DW + 1));

  assert_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> oe_run_q == 6'(DW + 1));

  assert_no_wr_while_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> !mdio_oe_o && !rd_en);

  assert_clear_on_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rd_en && reg_addr == 5'd23) |-> irq_stat == $past(irq_src_i));

  assert_irq_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> ($past(|irq_src_i) || $past(wr_en)));
endmodule

bind mdio_mgmt_slave mdio_mgmt_checker #(.DW(DW)) i_chk (
  .clk_i     (mdc_i),
  .rst_ni    (rst_ni),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .irq_o     (irq_o),
  .irq_src_i (irq_src_i),
  .rd_en     (rd_en),
  .wr_en     (wr_en),
  .reg_addr  (reg_addr),
  .irq_stat  (irq_stat)
);

// File: tb/test_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module test_mdio_mgmt_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mst_bit = 1'b1;
  logic [4:0]  phy_addr = 5'h0B;
  logic [15:0] src = '0;
  logic        mdio_o, mdio_oe, irq;
  logic        line;

  always #2.5 clk = ~clk;

  assign line = mdio_oe ? mdio_o : mst_bit;

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .mdc_i      (clk),
    .rst_ni     (rst_n),
    .mdio_i     (line),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe),
    .phy_addr_i (phy_addr),
    .irq_src_i  (src),
    .irq_o      (irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [15:0] m_ctrl = 16'h3100, m_adv = 16'h01E1, m_ien = '0, m_stat = '0;
  logic        exp_irq = 1'b0;
  logic [15:0] pend_src = '0;
  bit          pend_clr = 0, pend_wr = 0;
  logic [4:0]  pend_wa;
  logic [15:0] pend_wd;

  function automatic logic [15:0] model_read(input logic [4:0] a);
    case (a)
      5'd0:  return m_ctrl;
      5'd1:  return 16'h7809;
      5'd2:  return 16'h0015;
      5'd3:  return 16'hF450;
      5'd4:  return m_adv;
      5'd22: return m_ien;
      5'd23: return m_stat;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input logic e_oe, input logic e_o, input string req);
    @(negedge clk);
    chk(req, mdio_oe, e_oe, "mdio_oe_o");
    if (e_oe) chk(req, mdio_o, e_o, "mdio_o");
    chk("R11", irq, exp_irq, "irq_o");
    mst_bit = b;
    src     = pend_src;
    m_stat  = (pend_clr ? 16'h0 : m_stat) | pend_src;
    if (pend_wr) begin
      case (pend_wa)
        5'd0:  m_ctrl = pend_wd;
        5'd4:  m_adv  = pend_wd;
        5'd22: m_ien  = pend_wd;
        default: ;
      endcase
    end
    pend_src = '0; pend_clr = 0; pend_wr = 0;
    exp_irq = |(m_stat & m_ien);
  endtask

  task automatic frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                       input bit valid, input logic [15:0] ta_src, input string req);
    logic [15:0] rv;
    for (int i = 0; i < pre; i++) step(1'b1, 1'b0, 1'b0, req);
    for (int i = 1; i >= 0; i--) step(st[i], 1'b0, 1'b0, req);
    for (int i = 1; i >= 0; i--) step(op[i], 1'b0, 1'b0, req);
    for (int i = 4; i >= 0; i--) step(pa[i], 1'b0, 1'b0, req);
    for (int i = 4; i >= 0; i--) step(ra[i], 1'b0, 1'b0, req);
    if (op == 2'b10) begin
      rv = model_read(ra);
      if (valid) begin
        pend_src = ta_src;
        pend_clr = (ra == 5'd23);
      end
      step(1'b1, 1'b0, 1'b0, "R5");
      step(1'b1, valid, 1'b0, req);
      for (int k = 15; k >= 0; k--) step(1'b1, valid, rv[k], req);
      step(1'b1, 1'b0, 1'b0, "R5");
    end else begin
      step(1'b1, 1'b0, 1'b0, req);
      step(1'b0, 1'b0, 1'b0, req);
      for (int k = 15; k >= 0; k--) begin
        if (k == 0 && valid) begin pend_wr = 1; pend_wa = ra; pend_wd = wd; end
        step(wd[k], 1'b0, 1'b0, req);
      end
      step(1'b1, 1'b0, 1'b0, req);
    end
  endtask

  task automatic rd(input logic [4:0] ra, input string req);
    frame(32, 2'b01, 2'b10, phy_addr, ra, 16'h0, 1, 16'h0, req);
  endtask

  task automatic wr(input logic [4:0] ra, input logic [15:0] d, input string req);
    frame(32, 2'b01, 2'b01, phy_addr, ra, d, 1, 16'h0, req);
  endtask

  initial begin
    // R1 reset state
    #1;
    repeat (3) @(negedge clk);
    chk("R1", mdio_oe, 1'b0, "mdio_oe_o in reset");
    chk("R1", irq, 1'b0, "irq_o in reset");
    rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, "R1");
    rd(5'd0, "R1"); rd(5'd4, "R1"); rd(5'd22, "R1");
    // R7 constants
    rd(5'd1, "R7"); rd(5'd2, "R7"); rd(5'd3, "R7"); rd(5'd5, "R7"); rd(5'd6, "R7");
    // R6 writes
    wr(5'd0, 16'hA5C3, "R6"); rd(5'd0, "R6");
    wr(5'd4, 16'h1234, "R6"); rd(5'd4, "R6");
    // R7 RO writes ignored
    wr(5'd1, 16'hFFFF, "R7"); rd(5'd1, "R7");
    wr(5'd6, 16'hFFFF, "R7"); rd(5'd6, "R7");
    // R8 unmapped
    wr(5'd10, 16'hBEEF, "R8"); rd(5'd10, "R8"); rd(5'd31, "R8");
    // R4 wrong address
    frame(32, 2'b01, 2'b10, 5'h0C, 5'd0, 16'h0, 0, 16'h0, "R4");
    frame(32, 2'b01, 2'b01, 5'h0C, 5'd0, 16'h0000, 0, 16'h0, "R4");
    rd(5'd0, "R4");
    phy_addr = 5'h1F;
    frame(32, 2'b01, 2'b10, 5'h0B, 5'd0, 16'h0, 0, 16'h0, "R4");
    rd(5'd4, "R4");
    phy_addr = 5'h0B;
    // R2 preamble length and start marker
    step(1'b0, 1'b0, 1'b0, "R2");
    frame(31, 2'b01, 2'b10, phy_addr, 5'd0, 16'h0, 0, 16'h0, "R2");
    step(1'b0, 1'b0, 1'b0, "R2");
    frame(32, 2'b01, 2'b10, phy_addr, 5'd0, 16'h0, 1, 16'h0, "R2");
    step(1'b0, 1'b0, 1'b0, "R2");
    frame(40, 2'b01, 2'b10, phy_addr, 5'd2, 16'h0, 1, 16'h0, "R2");
    step(1'b0, 1'b0, 1'b0, "R2");
    frame(32, 2'b00, 2'b10, phy_addr, 5'd0, 16'h0, 0, 16'h0, "R2");
    // R3 unused opcodes
    frame(32, 2'b01, 2'b11, phy_addr, 5'd0, 16'h0, 0, 16'h0, "R3");
    frame(32, 2'b01, 2'b00, phy_addr, 5'd0, 16'h0, 0, 16'h0, "R3");
    rd(5'd0, "R3");
    // R9 R10 R11 interrupts
    wr(5'd22, 16'h0005, "R11");
    pend_src = 16'h0002;
    step(1'b1, 1'b0, 1'b0, "R11");
    step(1'b1, 1'b0, 1'b0, "R11");
    rd(5'd23, "R9");
    rd(5'd23, "R10");
    pend_src = 16'h0004;
    step(1'b1, 1'b0, 1'b0, "R11");
    step(1'b1, 1'b0, 1'b0, "R11");
    frame(32, 2'b01, 2'b10, phy_addr, 5'd23, 16'h0, 1, 16'h0001, "R10");
    step(1'b1, 1'b0, 1'b0, "R10");
    rd(5'd23, "R10");
    step(1'b1, 1'b0, 1'b0, "R11");
    wr(5'd22, 16'h0000, "R11");
    pend_src = 16'h8000;
    step(1'b1, 1'b0, 1'b0, "R11");
    step(1'b1, 1'b0, 1'b0, "R11");
    rd(5'd23, "R9");
    step(1'b1, 1'b0, 1'b0, "R11");
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule